// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer. It is meant for the feedback path of a frequency synthesizer. A front-stage prescaler divides by ten or eleven. A swallow counter decides how many of the main-counter periods use the longer modulus. A 9-bit main counter sets how many prescaler periods make up one output cycle. With main value M and swallow value A, one output cycle lasts 10×(M+1)+A input clocks. Each output cycle ends with a single-clock pulse that goes to the phase comparator.

A bypass control removes the prescaler from the path. The prescaler is then held idle with its count frozen at zero. The chain divides by M+1 directly.

The configuration is latched only where one output cycle ends and the next begins. A change in mid-cycle therefore never shortens or stretches the period in progress. Two settings are illegal: M=0, and A larger than M+1. An illegal setting raises a flag and is repaired: M=0 runs as M=1, and A is clamped to M+1.

Top module: `fbdiv_chain`

## Requirements
- R1: With `presc_off` low, the spacing between consecutive `div_pulse` assertions is 10×(M+1)+A input clocks, for any legal M and A.
- R2: Within one output cycle, the first A prescaler periods last 11 clocks and the remaining M+1−A periods last 10 clocks. Once a cycle has switched to the short modulus, it stays there until the next cycle starts.
- R3: With `presc_off` high, the pulse spacing is M+1 clocks whatever the value of A, and the prescaler count stays at zero.
- R4: The smallest legal M of 1 gives a pulse spacing of 2 in bypass and 20+A with the prescaler in the path.
- R5: M, A and `presc_off` are sampled only at a cycle boundary. A change during a cycle leaves that cycle's length and `cfg_err` unchanged, and takes effect from the following cycle.
- R6: `div_pulse` is high for exactly one clock per output cycle.
- R7: M=0, or A>M+1, sets `cfg_err` for the cycle that uses that setting. M=0 then runs as M=1, and A is clamped to M+1 (the effective M).
- R8: While `rst_n` is low, `div_pulse` and `cfg_err` are low. The first clock edge after release loads the configuration, and the first pulse follows one full cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_val | input | 9 | Main counter setting M |
| a_val | input | 4 | Swallow count A |
| presc_off | input | 1 | High bypasses the prescaler and holds it idle |
| div_pulse | output | 1 | One-clock pulse at the end of each divide cycle |
| cfg_err | output | 1 | Illegal setting latched for the current cycle |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a running cycle. In that case the old length must be kept to the clock and the new one must start exactly at the next boundary. The stimulus first synchronises to a pulse, then counts a fixed number of clocks before it changes the inputs. It then measures the remaining part of the old cycle and the whole new cycle separately. It also drives an illegal setting mid-cycle and checks that the error flag does not move until the boundary. Full sweeps of small M over every A, including values past the clamp, cover how the modulus is split within a cycle.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // Main setting actually used: zero is repaired to one.
  function automatic int unsigned eff_main(int unsigned m);
    return (m == 0) ? 1 : m;
  endfunction

  // Swallow count actually used: never beyond effective main + 1.
  function automatic int unsigned eff_swallow(int unsigned a, int unsigned m);
    int unsigned lim;
    lim = eff_main(m) + 1;
    return (a > lim) ? lim : a;
  endfunction

  // Setting outside the legal range.
  function automatic bit cfg_bad(int unsigned m, int unsigned a);
    return (m == 0) || (a > m + 1);
  endfunction

  // Input clocks per output cycle for an already repaired setting.
  function automatic int unsigned chain_ratio(int unsigned m, int unsigned a,
                                              bit byp, int unsigned base);
    return byp ? (m + 1) : (base * (m + 1) + a);
  endfunction

endpackage

// File: rtl/fbdiv_cfg_sampler.sv
module fbdiv_cfg_sampler #(
  parameter int unsigned M_W = 9,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           byp_in,
  output logic [M_W-1:0] nxt_m,
  output logic [A_W-1:0] nxt_a,
  output logic [M_W-1:0] act_m,
  output logic [A_W-1:0] act_a,
  output logic           act_byp,
  output logic           cfg_err
);
  import fbdiv_pkg::*;

  logic bad_now;

  // Repaired values; the clamped swallow is never above a_in, so it fits A_W.
  assign nxt_m   = M_W'(eff_main(32'(m_in)));
  assign nxt_a   = A_W'(eff_swallow(32'(a_in), 32'(m_in)));
  assign bad_now = cfg_bad(32'(m_in), 32'(a_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_m   <= M_W'(1);
      act_a   <= '0;
      act_byp <= 1'b0;
      cfg_err <= 1'b0;
    end else if (load) begin
      act_m   <= nxt_m;
      act_a   <= nxt_a;
      act_byp <= byp_in;
      cfg_err <= bad_now;
    end
  end

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int unsigned BASE = 10,
  localparam int unsigned CW  = $clog2(BASE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          restart,
  input  logic          mod_hi,
  output logic          pre_tick,
  output logic [CW-1:0] pre_cnt
);
  logic [CW-1:0] last_cnt;

  // Divide by BASE+1 while the swallow counter asks for it, else by BASE.
  assign last_cnt = mod_hi ? CW'(BASE) : CW'(BASE - 1);
  assign pre_tick = run && (pre_cnt == last_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_cnt <= '0;
    else if (!run || restart || pre_tick)
      pre_cnt <= '0;
    else
      pre_cnt <= pre_cnt + CW'(1);
  end

endmodule

// File: rtl/fbdiv_swallow_ctl.sv
module fbdiv_swallow_ctl #(
  parameter int unsigned M_W = 9,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [M_W-1:0] ld_m,
  input  logic [A_W-1:0] ld_a,
  output logic           mod_hi,
  output logic           cycle_end,
  output logic [M_W-1:0] m_cnt,
  output logic [A_W-1:0] a_left
);
  // The main counter runs M..0, one step per prescaler period.
  // The swallow counter runs down alongside it and holds the long modulus while nonzero.
  assign mod_hi    = (a_left != '0);
  assign cycle_end = step && (m_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt  <= '0;
      a_left <= '0;
    end else if (load) begin
      m_cnt  <= ld_m;
      a_left <= ld_a;
    end else if (step) begin
      if (m_cnt != '0) m_cnt  <= m_cnt - M_W'(1);
      if (mod_hi)      a_left <= a_left - A_W'(1);
    end
  end

endmodule

// File: rtl/fbdiv_chain.sv
module fbdiv_chain #(
  parameter int unsigned M_W  = 9,
  parameter int unsigned A_W  = 4,
  parameter int unsigned BASE = 10,
  localparam int unsigned CW  = $clog2(BASE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           presc_off,
  output logic           div_pulse,
  output logic           cfg_err
);
  logic           fresh;
  logic           load;
  logic           step;
  logic           pre_tick;
  logic [CW-1:0]  pre_cnt;
  logic           mod_hi;
  logic           cycle_end;
  logic [M_W-1:0] m_cnt;
  logic [A_W-1:0] a_left;
  logic [M_W-1:0] nxt_m;
  logic [A_W-1:0] nxt_a;
  logic [M_W-1:0] act_m;
  logic [A_W-1:0] act_a;
  logic           act_byp;

  assign load = fresh || cycle_end;
  assign step = act_byp || pre_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh     <= 1'b1;
      div_pulse <= 1'b0;
    end else begin
      fresh     <= 1'b0;
      div_pulse <= cycle_end && !fresh;
    end
  end

  fbdiv_cfg_sampler #(.M_W(M_W), .A_W(A_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .m_in(m_val), .a_in(a_val), .byp_in(presc_off),
    .nxt_m(nxt_m), .nxt_a(nxt_a),
    .act_m(act_m), .act_a(act_a), .act_byp(act_byp), .cfg_err(cfg_err)
  );

  fbdiv_prescaler #(.BASE(BASE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(!act_byp), .restart(load),
    .mod_hi(mod_hi), .pre_tick(pre_tick), .pre_cnt(pre_cnt)
  );

  fbdiv_swallow_ctl #(.M_W(M_W), .A_W(A_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .ld_m(nxt_m), .ld_a(nxt_a),
    .mod_hi(mod_hi), .cycle_end(cycle_end), .m_cnt(m_cnt), .a_left(a_left)
  );

endmodule

// File: rtl/fbdiv_chain_chk.sv
module fbdiv_chain_chk #(
  parameter int unsigned M_W  = 9,
  parameter int unsigned A_W  = 4,
  parameter int unsigned BASE = 10,
  localparam int unsigned CW  = $clog2(BASE + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [M_W-1:0] m_val,
  input logic [A_W-1:0] a_val,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic           load,
  input logic           mod_hi,
  input logic [M_W-1:0] m_cnt,
  input logic [A_W-1:0] a_left,
  input logic [CW-1:0]  pre_cnt,
  input logic           pre_tick,
  input logic [M_W-1:0] act_m,
  input logic [A_W-1:0] act_a,
  input logic           act_byp
);
  import fbdiv_pkg::*;

  logic [31:0] gap;
  logic [31:0] exp_len;
  logic        armed;

  // Clocks between pulses, compared with the ratio of the cycle that just ran.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= '0;
      exp_len <= '0;
      armed   <= 1'b0;
    end else if (div_pulse) begin
      gap     <= 32'd1;
      exp_len <= chain_ratio(32'(act_m), 32'(act_a), act_byp, BASE);
      armed   <= 1'b1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  AST_PERIOD_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && div_pulse) |-> (gap == exp_len)); // R1

  AST_SHORT_MOD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mod_hi && !load) |=> !mod_hi); // R2

  AST_PRESC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    act_byp |-> ((pre_cnt == '0) && !pre_tick)); // R3

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(act_m) && $stable(act_a) && $stable(act_byp) && $stable(cfg_err))); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R6

  AST_SWALLOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(a_left) <= 32'(m_cnt) + 32'd1)); // R7

  AST_ERR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_err == cfg_bad(32'($past(m_val)), 32'($past(a_val))))); // R7

endmodule

bind fbdiv_chain fbdiv_chain_chk #(.M_W(M_W), .A_W(A_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
  .div_pulse(div_pulse), .cfg_err(cfg_err), .load(load), .mod_hi(mod_hi),
  .m_cnt(m_cnt), .a_left(a_left), .pre_cnt(pre_cnt), .pre_tick(pre_tick),
  .act_m(act_m), .act_a(act_a), .act_byp(act_byp)
);

// File: tb/test_fbdiv_chain.sv
module test_fbdiv_chain;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 6000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] m_val = '0;
  logic [3:0] a_val = '0;
  logic       presc_off = 1'b0;
  logic       div_pulse;
  logic       cfg_err;

  int checks = 0;
  int errs   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fbdiv_chain i_fbdiv_chain (
    .clk(clk), .rst_n(rst_n), .m_val(m_val), .a_val(a_val),
    .presc_off(presc_off), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  // Expected spacing, from the requirement text.
  function automatic int want_len(int m, int a, bit byp);
    int me, ae;
    me = (m == 0) ? 1 : m;
    ae = (a > me + 1) ? me + 1 : a;
    if (byp) return me + 1;
    return 10 * me + 10 + ae;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_pulse();
    int n = 0;
    @(negedge clk);
    while (!div_pulse && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_to_pulse(output int n);
    n = 1;
    @(negedge clk);
    while (!div_pulse && n < LIM) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_cfg(int m, int a, bit byp, string req);
    int n;
    bit bad;
    bad = (m == 0) || (a > m + 1);
    @(negedge clk);
    m_val = 9'(m);
    a_val = 4'(a);
    presc_off = byp;
    wait_pulse();
    chk(cfg_err == bad, bad ? "R7" : req, int'(cfg_err), int'(bad), "cfg_err");
    count_to_pulse(n);
    chk(n == want_len(m, a, byp), req, n, want_len(m, a, byp), "pulse spacing");
    @(negedge clk);
    chk(!div_pulse, "R6", int'(div_pulse), 0, "pulse width");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n;
    // R8: reset state, then the first pulse one full cycle after release
    m_val = 9'd1; a_val = 4'd0; presc_off = 1'b1;
    repeat (3) @(negedge clk);
    chk(!div_pulse, "R8", int'(div_pulse), 0, "pulse in reset");
    chk(!cfg_err, "R8", int'(cfg_err), 0, "err in reset");
    rst_n = 1'b1;
    count_to_pulse(n);
    chk(n == 3, "R8", n, 3, "first pulse after release");

    // R4: smallest legal main setting
    run_cfg(1, 0, 1'b1, "R4");
    for (int a = 0; a <= 2; a++) run_cfg(1, a, 1'b0, "R4");

    // R1 / R2 / R7: full sweep of small settings, A past the clamp
    for (int m = 1; m <= 9; m++)
      for (int a = 0; a <= m + 2; a++)
        run_cfg(m, a, 1'b0, (a > 0) ? "R2" : "R1");

    // R3: bypass, A ignored
    for (int m = 1; m <= 24; m++) run_cfg(m, m % 5, 1'b1, "R3");

    // R1 / R3: widest main setting
    run_cfg(511, 15, 1'b0, "R1");
    run_cfg(511, 15, 1'b1, "R3");
    run_cfg(8, 9, 1'b0, "R1");

    // R7: illegal settings repaired
    run_cfg(0, 0, 1'b0, "R7");
    run_cfg(0, 5, 1'b0, "R7");
    run_cfg(0, 3, 1'b1, "R7");
    run_cfg(3, 15, 1'b0, "R7");

    // R5: mid-cycle change keeps the running cycle
    run_cfg(3, 2, 1'b0, "R5");
    repeat (5) @(negedge clk);
    m_val = 9'd6; a_val = 4'd1; presc_off = 1'b0;
    count_to_pulse(n);
    chk(n == 42 - 6, "R5", n, 36, "remaining old cycle");
    chk(!cfg_err, "R5", int'(cfg_err), 0, "err at boundary of legal cfg");
    count_to_pulse(n);
    chk(n == 71, "R5", n, 71, "new cycle length");
    repeat (4) @(negedge clk);
    m_val = 9'd0; a_val = 4'd9;
    repeat (10) @(negedge clk);
    chk(!cfg_err, "R5", int'(cfg_err), 0, "err held mid-cycle");
    wait_pulse();
    chk(cfg_err, "R7", int'(cfg_err), 1, "err after boundary");
    count_to_pulse(n);
    chk(n == 22, "R7", n, 22, "repaired cycle length");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule